// File: doc/BRIEF.md
# DRAM Refresh and Start-up Sequencer

This block keeps an asynchronous DRAM with a row-counter refresh mode alive. After reset it holds off all strobe activity for a programmable power-up pause. It then runs a fixed number of wake-up refresh cycles and raises `init_done`. From then on a free-running interval timer adds one owed refresh to a small backlog every `INTERVAL_CYC` clocks. While anything is owed, the sequencer asks the access controller for the bus. Once granted, it drives the row and column strobes itself for one complete refresh cycle per owed entry.

By default each refresh is of the column-strobe-first kind. Both byte column strobes go low a programmable setup time before the row strobe falls and stay low for the whole row-strobe pulse. The DRAM's own row counter therefore picks the row, and the address bus is not driven. A parameter selects the other variant, a row-strobe-only refresh. In that mode the sequencer keeps its own row counter, drives that counter on the address bus with an enable, and advances it after every cycle. If the access controller withholds the bus for so long that the backlog would pass `MAX_BACKLOG`, the data may no longer be trusted. The sequencer then drops `init_done` and repeats the whole wake-up series.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_lo_n` and `cas_hi_n` are 1, and `ref_req`, `init_done` and `row_addr_en` are 0.
- R2: `ref_req` is 0 for the first `PAUSE_CYC-1` clocks after reset release and rises after clock `PAUSE_CYC`. With the grant held high, the first row-strobe fall follows clock `PAUSE_CYC+1+SETUP_CYC`.
- R3: Exactly `WAKE_CNT` refresh cycles run before `init_done` rises. `init_done` rises `PRECH_CYC` clocks after the last wake-up row-strobe rise.
- R4: In the default mode, every row-strobe fall is preceded by exactly `SETUP_CYC` clocks with both column strobes low. Both column strobes stay low while the row strobe is low and rise together with it. `row_addr_en` stays 0.
- R5: Each row-strobe pulse is low for `ACTIVE_CYC` clocks. Back-to-back cycles with the grant held show `PRECH_CYC+1+SETUP_CYC` clocks from a row-strobe rise to the next fall.
- R6: After `init_done`, with the grant held high, consecutive refresh cycles start exactly `INTERVAL_CYC` clocks apart.
- R7: `ref_req` stays 1 while refresh is owed and no grant is given. No refresh cycle starts without `ref_gnt`.
- R8: A backlog of up to `MAX_BACKLOG` owed refreshes is worked off once the grant returns, and `init_done` stays 1. Whenever `ref_req` is 0, the number of refresh cycles since `init_done` rose equals the number of elapsed intervals.
- R9: If a new interval would push the backlog above `MAX_BACKLOG`, `init_done` falls. Exactly `WAKE_CNT` cycles are then rerun before it rises again.
- R10: With `RAS_ONLY=1`, both column strobes stay 1 and `row_addr_en` is 1 while the row strobe is low. `row_addr` starts at 0 after reset and advances by one per cycle, modulo 2^`ROW_BITS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_req | output | 1 | Bus request to the access controller, held through the refresh cycle |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower byte column strobe, active low |
| cas_hi_n | output | 1 | Upper byte column strobe, active low |
| row_addr | output | ROW_BITS | Refresh row address in the row-strobe-only variant, 0 otherwise |
| row_addr_en | output | 1 | Address bus drive enable for `row_addr` |
| init_done | output | 1 | Start-up series complete, DRAM usable |

## Verification
The hardest state to reach is the edge of the backlog limit. The bench has to owe exactly `MAX_BACKLOG` refreshes without tipping over, and one more must restart the wake-up series. The bench gets there by waiting for a refresh to start, which aligns it to the interval grid. It then withdraws the grant for a window that holds exactly `MAX_BACKLOG` interval ticks, and later for one two ticks longer. After each window it compares the count of completed cycles with the elapsed interval count at the first idle point. A second instance in row-strobe-only mode, with a 3-bit row counter, runs through the same traffic, so its address wraps several times.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_PRECH  = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    SQ_PAUSE = 2'd0,
    SQ_WAKE  = 2'd1,
    SQ_RUN   = 2'd2
  } seq_t;
endpackage

// File: rtl/rfr_interval_timer.sv
module rfr_interval_timer #(
  parameter int PERIOD = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/rfr_strobe_gen.sv
module rfr_strobe_gen import rfr_pkg::*; #(
  parameter int SETUP_CYC  = 1,
  parameter int ACTIVE_CYC = 4,
  parameter int PRECH_CYC  = 3,
  parameter bit RAS_ONLY   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n,
  output logic addr_en
);
  localparam int M1   = (SETUP_CYC > ACTIVE_CYC) ? SETUP_CYC : ACTIVE_CYC;
  localparam int MAXC = (M1 > PRECH_CYC) ? M1 : PRECH_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  phase_t        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ras_d, cas_d, aen_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = CW'(SETUP_CYC - 1);
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_ACTIVE;
          cnt_d   = CW'(ACTIVE_CYC - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_ACTIVE: begin
        if (cnt_q == '0) begin
          phase_d = PH_PRECH;
          cnt_d   = CW'(PRECH_CYC - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_PRECH: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
          done    = 1'b1;
        end else cnt_d = cnt_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
    ras_d = (phase_d != PH_ACTIVE);
    if (RAS_ONLY) begin
      cas_d = 1'b1;
      aen_d = (phase_d == PH_SETUP) || (phase_d == PH_ACTIVE);
    end else begin
      cas_d = !((phase_d == PH_SETUP) || (phase_d == PH_ACTIVE));
      aen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      addr_en <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      ras_n   <= ras_d;
      cas_n   <= cas_d;
      addr_en <= aen_d;
    end
  end

  assign busy = (phase_q != PH_IDLE);

  generate
    if (RAS_ONLY) begin : g_ro_chk
      a_r10_addr_with_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (addr_en && cas_n));
    end else begin : g_cbr_chk
      a_r4_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));
      a_r4_cas_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> ras_n && $past(!ras_n));
    end
  endgenerate
endmodule

// File: rtl/rfr_row_counter.sv
module rfr_row_counter #(
  parameter int ROW_BITS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc,
  output logic [ROW_BITS-1:0] row
);
  logic [ROW_BITS-1:0] row_d;

  always_comb begin
    row_d = row;
    if (inc) row_d = row + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row <= '0;
    else        row <= row_d;
  end

  a_r10_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> row == $past(row) + 1'b1);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq import rfr_pkg::*; #(
  parameter int PAUSE_CYC    = 20000,
  parameter int WAKE_CNT     = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int SETUP_CYC    = 1,
  parameter int ACTIVE_CYC   = 4,
  parameter int PRECH_CYC    = 3,
  parameter int MAX_BACKLOG  = 8,
  parameter int ROW_BITS     = 9,
  parameter bit RAS_ONLY     = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                ref_req,
  input  logic                ref_gnt,
  output logic                ras_n,
  output logic                cas_lo_n,
  output logic                cas_hi_n,
  output logic [ROW_BITS-1:0] row_addr,
  output logic                row_addr_en,
  output logic                init_done
);
  localparam int PW  = $clog2(PAUSE_CYC + 1);
  localparam int WW  = $clog2(WAKE_CNT + 1);
  localparam int BW  = $clog2(MAX_BACKLOG + 2);
  localparam int BW1 = BW + 1;

  seq_t           state_q, state_d;
  logic [PW-1:0]  pause_q, pause_d;
  logic [WW-1:0]  wake_q, wake_d;
  logic [BW-1:0]  backlog_q, backlog_d;
  logic [BW1-1:0] backlog_sum;
  logic           init_q, init_d;
  logic           tick, busy, done, start, cas_n;

  rfr_interval_timer #(.PERIOD(INTERVAL_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (state_q == SQ_RUN),
    .tick (tick)
  );

  rfr_strobe_gen #(
    .SETUP_CYC (SETUP_CYC),
    .ACTIVE_CYC(ACTIVE_CYC),
    .PRECH_CYC (PRECH_CYC),
    .RAS_ONLY  (RAS_ONLY)
  ) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .addr_en(row_addr_en)
  );

  generate
    if (RAS_ONLY) begin : g_row
      rfr_row_counter #(.ROW_BITS(ROW_BITS)) u_row (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (done),
        .row  (row_addr)
      );
    end else begin : g_norow
      assign row_addr = '0;
    end
  endgenerate

  assign cas_lo_n  = cas_n;
  assign cas_hi_n  = cas_n;
  assign init_done = init_q;

  always_comb begin
    ref_req = (state_q == SQ_WAKE) || ((state_q == SQ_RUN) && (backlog_q != '0)) || busy;
    start   = ref_req && ref_gnt && !busy;
  end

  always_comb begin
    backlog_sum = {1'b0, backlog_q} + BW1'(tick) - BW1'(done && (backlog_q != '0));
    state_d     = state_q;
    pause_d     = pause_q;
    wake_d      = wake_q;
    backlog_d   = backlog_q;
    init_d      = init_q;
    unique case (state_q)
      SQ_PAUSE: begin
        if (pause_q == PW'(PAUSE_CYC - 1)) begin
          state_d = SQ_WAKE;
          wake_d  = WW'(WAKE_CNT);
        end else pause_d = pause_q + 1'b1;
      end
      SQ_WAKE: begin
        if (done) begin
          if (wake_q <= WW'(1)) begin
            state_d   = SQ_RUN;
            init_d    = 1'b1;
            backlog_d = '0;
          end else wake_d = wake_q - 1'b1;
        end
      end
      SQ_RUN: begin
        if (backlog_sum > BW1'(MAX_BACKLOG)) begin
          state_d   = SQ_WAKE;
          init_d    = 1'b0;
          wake_d    = WW'(WAKE_CNT);
          backlog_d = '0;
        end else backlog_d = backlog_sum[BW-1:0];
      end
      default: state_d = SQ_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_PAUSE;
      pause_q   <= '0;
      wake_q    <= '0;
      backlog_q <= '0;
      init_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      pause_q   <= pause_d;
      wake_q    <= wake_d;
      backlog_q <= backlog_d;
      init_q    <= init_d;
    end
  end

  a_r2_quiet_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_PAUSE) |-> (ras_n && !ref_req && !init_done));
  a_r3_ready_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(done));
  a_r7_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt && !busy) |=> ref_req);
  a_r7_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ref_gnt));
  a_r8_backlog_bound: assert property (@(posedge clk) disable iff (!rst_n)
    backlog_q <= BW'(MAX_BACKLOG));
endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int P_PAUSE = 20;
  localparam int P_WAKE  = 8;
  localparam int P_INT   = 40;
  localparam int P_S     = 2;
  localparam int P_R     = 3;
  localparam int P_P     = 2;
  localparam int P_MAX   = 3;
  localparam int P_RB    = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_gnt;
  logic ref_req, ras_n, cas_lo_n, cas_hi_n, row_addr_en, init_done;
  logic [P_RB-1:0] row_addr;
  logic ro_req, ro_ras_n, ro_cas_lo_n, ro_cas_hi_n, ro_aen, ro_init;
  logic [P_RB-1:0] ro_row;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(.PAUSE_CYC(P_PAUSE), .WAKE_CNT(P_WAKE), .INTERVAL_CYC(P_INT),
    .SETUP_CYC(P_S), .ACTIVE_CYC(P_R), .PRECH_CYC(P_P), .MAX_BACKLOG(P_MAX),
    .ROW_BITS(P_RB), .RAS_ONLY(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_gnt), .ras_n(ras_n),
    .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n), .row_addr(row_addr),
    .row_addr_en(row_addr_en), .init_done(init_done));

  dram_refresh_seq #(.PAUSE_CYC(P_PAUSE), .WAKE_CNT(P_WAKE), .INTERVAL_CYC(P_INT),
    .SETUP_CYC(P_S), .ACTIVE_CYC(P_R), .PRECH_CYC(P_P), .MAX_BACKLOG(P_MAX),
    .ROW_BITS(P_RB), .RAS_ONLY(1'b1)) uut_ro (
    .clk(clk), .rst_n(rst_n), .ref_req(ro_req), .ref_gnt(ref_gnt), .ras_n(ro_ras_n),
    .cas_lo_n(ro_cas_lo_n), .cas_hi_n(ro_cas_hi_n), .row_addr(ro_row),
    .row_addr_en(ro_aen), .init_done(ro_init));

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc++;

  bit ras_p = 1, init_p = 0, first_seen = 0, first_wake = 1, steady = 0;
  bit gnt_low_p = 0, cas_ok = 1, drop_seen = 0;
  int cas_run = 0, ras_run = 0, last_rise = 0, wake_falls = 0, last_wake = 0;
  int run_falls = 0, init_cyc = 0, last_run_fall = -1, steady_n = 0, falls_nogrant = 0;
  bit ro_ras_p = 1;
  int exp_row = 0, ro_falls = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cyc == P_PAUSE - 1) chk(ref_req == 0, "R2 req before pause end", ref_req, 0);
      if (cyc == P_PAUSE)     chk(ref_req == 1, "R2 req after pause", ref_req, 1);
      if (ras_p && !ras_n) begin
        chk(!cas_lo_n && !cas_hi_n, "R4 both cas low at ras fall", {cas_hi_n, cas_lo_n}, 0);
        chk(cas_run == P_S, "R4 cas setup clocks", cas_run, P_S);
        chk(row_addr_en == 0, "R4 address not driven", row_addr_en, 0);
        if (!first_seen) begin
          chk(cyc == P_PAUSE + 1 + P_S, "R2 first ras fall", cyc, P_PAUSE + 1 + P_S);
          first_seen = 1;
        end
        if (!init_done) begin
          if (first_wake && wake_falls > 0)
            chk(cyc - last_rise == P_P + 1 + P_S, "R5 back-to-back gap", cyc - last_rise, P_P + 1 + P_S);
          wake_falls++;
        end else begin
          run_falls++;
          if (steady && last_run_fall >= 0) begin
            chk(cyc - last_run_fall == P_INT, "R6 refresh spacing", cyc - last_run_fall, P_INT);
            steady_n++;
          end
          last_run_fall = cyc;
        end
        if (gnt_low_p) falls_nogrant++;
      end
      if (!ras_p && ras_n) begin
        chk(ras_run == P_R, "R5 ras low width", ras_run, P_R);
        chk(cas_lo_n && cas_hi_n, "R4 cas rises with ras", {cas_hi_n, cas_lo_n}, 3);
        chk(cas_ok, "R4 cas low throughout ras", cas_ok, 1);
        last_rise = cyc;
      end
      if (!init_p && init_done) begin
        chk(wake_falls == P_WAKE, "R3 wake cycle count", wake_falls, P_WAKE);
        chk(cyc - last_rise == P_P, "R3 ready delay", cyc - last_rise, P_P);
        last_wake = wake_falls;
        wake_falls = 0;
        init_cyc = cyc;
        run_falls = 0;
        last_run_fall = -1;
        first_wake = 0;
      end
      if (init_p && !init_done) begin
        drop_seen = 1;
        wake_falls = 0;
      end
      if (!ras_n) begin
        ras_run++;
        if (cas_lo_n || cas_hi_n) cas_ok = 0;
      end else begin
        ras_run = 0;
        cas_ok = 1;
        if (!cas_lo_n) cas_run++; else cas_run = 0;
      end
      if (ro_ras_p && !ro_ras_n) begin
        chk(ro_aen == 1, "R10 address enabled", ro_aen, 1);
        chk(ro_row == P_RB'(exp_row), "R10 row address", ro_row, exp_row);
        chk(ro_cas_lo_n && ro_cas_hi_n, "R10 cas idle", {ro_cas_hi_n, ro_cas_lo_n}, 3);
        exp_row = (exp_row + 1) % (1 << P_RB);
        ro_falls++;
      end
      ras_p = ras_n;
      ro_ras_p = ro_ras_n;
      init_p = init_done;
      gnt_low_p = !ref_gnt;
    end
  end

  task automatic wait_init();
    while (!init_done) @(negedge clk);
  endtask

  task automatic withhold(input int len);
    int n = run_falls;
    while (run_falls == n) @(negedge clk);
    @(posedge clk); #1 ref_gnt = 0;
    repeat (len) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regrant();
    @(posedge clk); #1 ref_gnt = 1;
  endtask

  task automatic drain_check(input string tag);
    int k = 0;
    @(negedge clk);
    while (ref_req && k < 1000) begin
      @(negedge clk);
      k++;
    end
    chk(run_falls == (cyc - init_cyc) / P_INT, tag, run_falls, (cyc - init_cyc) / P_INT);
  endtask

  initial begin
    rst_n = 0;
    ref_gnt = 0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_lo_n && cas_hi_n, "R1 strobes idle", {ras_n, cas_hi_n, cas_lo_n}, 7);
    chk(!ref_req && !init_done && !row_addr_en, "R1 flags low", {ref_req, init_done, row_addr_en}, 0);
    chk(ro_ras_n && !ro_aen && !ro_req && ro_row == '0, "R1 ras-only idle", {ro_ras_n, ro_aen, ro_req}, 4);
    rst_n = 1;
    ref_gnt = 1;
    wait_init();
    steady = 1;
    while (steady_n < 5) @(negedge clk);
    steady = 0;
    withhold(P_MAX * P_INT);
    chk(ref_req == 1, "R7 request held without grant", ref_req, 1);
    chk(falls_nogrant == 0, "R7 no cycle without grant", falls_nogrant, 0);
    chk(init_done == 1, "R8 limit backlog tolerated", init_done, 1);
    regrant();
    drain_check("R8 cycles equal intervals after backlog");
    chk(drop_seen == 0, "R8 ready never dropped", drop_seen, 0);
    withhold((P_MAX + 2) * P_INT);
    chk(init_done == 0, "R9 ready dropped on overrun", init_done, 0);
    chk(ref_req == 1, "R9 request after overrun", ref_req, 1);
    chk(falls_nogrant == 0, "R7 no cycle during overrun", falls_nogrant, 0);
    regrant();
    wait_init();
    chk(last_wake == P_WAKE, "R9 wake rerun count", last_wake, P_WAKE);
    repeat (3 * P_INT) @(negedge clk);
    drain_check("R8 cycles equal intervals after rerun");
    chk(ro_falls > (1 << P_RB), "R10 row counter wrapped", ro_falls, (1 << P_RB) + 1);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R3 act=0 exp=1");
      report();
    end
  end
endmodule